// File: doc/BRIEF.md
# ALU Status Flag Generator

This block produces the result of an integer ALU operation and the arithmetic condition flags that go with it. It keeps every status bit in one 16-bit flags word whose bit positions are fixed. The operands may be 8, 16 or 32 bits wide. The supported operations are add, add with carry-in, subtract, subtract with borrow-in, AND, OR and XOR.

The result output is combinational. It follows the operands, the operation code, the size code and the stored carry flag. The flags word is registered and changes on the clock edge after a valid operation.

Each operation comes with a per-flag update policy that the instruction decoder supplies. The policy chooses, flag by flag, whether to compute the flag from the result, force it to 0, force it to 1, or leave it undefined. An undefined flag keeps its previous value.

Three control bits sit in the same word: a string-direction bit, an interrupt-enable bit and a single-step bit. Arithmetic never touches them. They change only through dedicated set and clear strobes, or through a load of the whole word.

Top module: `sfg_status_unit`

## Requirements
- R1: The flags word places carry at bit 0, parity at bit 2, nibble carry at bit 4, zero at bit 6, sign at bit 7, single-step at bit 8, interrupt enable at bit 9, direction at bit 10 and overflow at bit 11. All other bits always read 0, including after a whole-word load, and a synchronous active-low reset clears the whole word.
- R2: The result is the operation on the low 8, 16 or 32 operand bits, zero-extended to 32 bits. Operand bits above the selected size are ignored. The operation codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR and 7 reserved. The reserved code yields result 0. The size codes are 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits.
- R3: Add with carry adds the stored carry flag. Subtract with borrow also subtracts the stored carry flag. On add, carry is the carry out of the top bit at the selected size. On subtract, carry is set when the unsigned minuend is smaller than the subtrahend plus the borrow-in.
- R4: On add, overflow is set when both operands have the same sign and the result sign differs from it. On subtract, overflow is set when the operand signs differ and the result sign differs from the sign of the minuend.
- R5: Sign equals the top result bit at the selected size. Zero is set exactly when the result at that size is all zeros.
- R6: Parity is set when the low result byte holds an even number of ones, whatever the size.
- R7: Nibble carry is set when a carry (on add) or a borrow (on subtract) passes between result bit 3 and bit 4.
- R8: Logic operations compute carry and overflow as 0 and leave the nibble carry unchanged.
- R9: The policy input holds two bits per flag. Carry sits at [1:0], parity at [3:2], nibble carry at [5:4], zero at [7:6], sign at [9:8] and overflow at [11:10]. Code 0 computes the flag, 1 forces it to 0, 2 forces it to 1, and 3 keeps its previous value.
- R10: The direction, interrupt-enable and single-step bits change only through the set and clear strobes or a load. The strobe bits map as bit 0 to direction, bit 1 to interrupt enable and bit 2 to single-step. When set and clear hit the same bit, clear wins. Strobes act in the same cycle as an ALU operation and do not disturb its flags.
- R11: A whole-word load takes priority over an ALU operation and over the strobes in the same cycle.
- R12: The arithmetic flags stay unchanged when no operation is valid or when the operation code is reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An ALU operation executes this cycle |
| op_code | input | 3 | Operation code |
| op_size | input | 2 | Operand size code |
| opnd_a | input | 32 | First operand (minuend on subtract) |
| opnd_b | input | 32 | Second operand |
| flag_policy | input | 12 | Two-bit update policy per arithmetic flag |
| ctl_set | input | 3 | Set strobes for direction, interrupt enable, single-step |
| ctl_clr | input | 3 | Clear strobes for the same three bits |
| load_en | input | 1 | Load the whole flags word |
| load_word | input | 16 | Value for the whole-word load |
| result | output | 32 | Zero-extended ALU result |
| flags | output | 16 | Registered flags word |

## Verification
Two kinds of update can land in the same cycle.

The first pair is an ALU operation together with a control-bit strobe. The bench issues an overflowing 8-bit add while it raises the direction and single-step set strobes. The word that follows must hold both the computed arithmetic flags and the new control bits.

The second pair is a whole-word load together with an operation or a strobe. Here the loaded value alone must appear, and the operation and the strobe must leave no trace.

// File: rtl/sfg_pkg.sv
// Shared types and constants for the status flag generator.
// Assumes a 32-bit datapath and a 16-bit flags word with fixed bit positions.
package sfg_pkg;
    localparam int DATA_W    = 32;
    localparam int FLAGS_W   = 16;
    localparam int LANE_BASE = 8;
    localparam int NUM_LANES = 3;
    localparam int NUM_AF    = 6;  // arithmetic flags: C P A Z S O
    localparam int NUM_CTL   = 3;  // direction, interrupt, single-step
    localparam int POL_W     = 2;
    localparam logic [FLAGS_W-1:0] USED_MASK = 16'h0FD5;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
        OP_AND = 3'd4, OP_OR  = 3'd5, OP_XOR = 3'd6, OP_RSV = 3'd7
    } alu_op_e;

    typedef enum logic [POL_W-1:0] {
        POL_CALC = 2'd0, POL_ZERO = 2'd1, POL_ONE = 2'd2, POL_KEEP = 2'd3
    } flag_pol_e;

    // Bit position of arithmetic flag k (order C P A Z S O).
    function automatic int af_pos(input int k);
        case (k)
            0: af_pos = 0;
            1: af_pos = 2;
            2: af_pos = 4;
            3: af_pos = 6;
            4: af_pos = 7;
            default: af_pos = 11;
        endcase
    endfunction

    // Bit position of control bit j (order direction, interrupt, single-step).
    function automatic int ctl_pos(input int j);
        ctl_pos = 10 - j;
    endfunction
endpackage

// File: rtl/sfg_arith.sv
// Result datapath: one add/logic lane per operand size, then a size select.
// Assumes the lane widths are LANE_BASE doubled per lane, the last lane being DATA_W.
// Raw carry, overflow, sign and zero come from the selected lane.
module sfg_arith
    import sfg_pkg::*;
(
    input  logic [2:0]        op_code,
    input  logic [1:0]        op_size,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              c_raw,
    output logic              o_raw,
    output logic              s_raw,
    output logic              z_raw,
    output logic              is_logic
);
    logic              is_sub;
    logic              use_cin;
    logic              cin_eff;
    logic [DATA_W-1:0] lane_res [NUM_LANES];
    logic [NUM_LANES-1:0] lane_c, lane_o, lane_s, lane_z;
    int unsigned       sel;

    // Decode the operation class and the effective carry-in.
    always_comb begin
        is_sub   = (op_code == OP_SUB) || (op_code == OP_SBB);
        use_cin  = (op_code == OP_ADC) || (op_code == OP_SBB);
        is_logic = (op_code == OP_AND) || (op_code == OP_OR) || (op_code == OP_XOR);
        cin_eff  = is_sub ? ~(use_cin & carry_in) : (use_cin & carry_in);
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam int W = LANE_BASE << i;
        logic [W-1:0] a_w, b_eff, r_w;
        logic [W:0]   sum;
        // Per-lane add (subtract via inverted operand) and logic result.
        always_comb begin
            a_w   = opnd_a[W-1:0];
            b_eff = is_sub ? ~opnd_b[W-1:0] : opnd_b[W-1:0];
            sum   = {1'b0, a_w} + {1'b0, b_eff} + {{W{1'b0}}, cin_eff};
            case (op_code)
                OP_AND:  r_w = a_w & opnd_b[W-1:0];
                OP_OR:   r_w = a_w | opnd_b[W-1:0];
                OP_XOR:  r_w = a_w ^ opnd_b[W-1:0];
                OP_RSV:  r_w = '0;
                default: r_w = sum[W-1:0];
            endcase
            lane_res[i] = DATA_W'(r_w);
            lane_c[i]   = is_logic ? 1'b0 : (sum[W] ^ is_sub);
            lane_o[i]   = is_logic ? 1'b0 :
                          ((a_w[W-1] == b_eff[W-1]) && (sum[W-1] != a_w[W-1]));
            lane_s[i]   = r_w[W-1];
            lane_z[i]   = (r_w == '0);
        end
    end

    // Pick the lane named by the size code; codes above the last lane use the widest.
    always_comb begin
        sel    = (op_size >= 2'(NUM_LANES - 1)) ? NUM_LANES - 1 : int'(op_size);
        result = lane_res[sel];
        c_raw  = lane_c[sel];
        o_raw  = lane_o[sel];
        s_raw  = lane_s[sel];
        z_raw  = lane_z[sel];
    end
endmodule

// File: rtl/sfg_flag_eval.sv
// Forms the computed arithmetic flags and applies the per-flag policy.
// Assumes the flag order C P A Z S O and that a held flag is taken from cur_flags.
module sfg_flag_eval
    import sfg_pkg::*;
(
    input  logic [DATA_W-1:0]        opnd_a,
    input  logic [DATA_W-1:0]        opnd_b,
    input  logic [DATA_W-1:0]        result,
    input  logic                     c_raw,
    input  logic                     o_raw,
    input  logic                     s_raw,
    input  logic                     z_raw,
    input  logic                     is_logic,
    input  logic [NUM_AF*POL_W-1:0]  flag_policy,
    input  logic [FLAGS_W-1:0]       cur_flags,
    output logic [NUM_AF-1:0]        af_next
);
    logic [NUM_AF-1:0] calc;
    logic [NUM_AF-1:0] keep_on_calc;

    // Computed values; the nibble carry is kept on logic operations.
    always_comb begin
        calc         = {o_raw, s_raw, z_raw,
                        opnd_a[4] ^ opnd_b[4] ^ result[4],
                        ~^result[7:0], c_raw};
        keep_on_calc = {3'b000, is_logic, 2'b00};
    end

    for (genvar k = 0; k < NUM_AF; k++) begin : g_pol
        localparam int P = af_pos(k);
        flag_pol_e pol;
        // Select the new value of flag k according to its policy field.
        always_comb begin
            pol = flag_pol_e'(flag_policy[k*POL_W +: POL_W]);
            case (pol)
                POL_CALC: af_next[k] = keep_on_calc[k] ? cur_flags[P] : calc[k];
                POL_ZERO: af_next[k] = 1'b0;
                POL_ONE:  af_next[k] = 1'b1;
                default:  af_next[k] = cur_flags[P];
            endcase
        end
    end
endmodule

// File: rtl/sfg_flag_reg.sv
// The flags word register: whole-word load, then ALU update and control strobes.
// Assumes strobes and ALU updates touch disjoint bits; clear beats set.
module sfg_flag_reg
    import sfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [FLAGS_W-1:0] load_word,
    input  logic               alu_upd,
    input  logic [NUM_AF-1:0]  af_next,
    input  logic [NUM_CTL-1:0] ctl_set,
    input  logic [NUM_CTL-1:0] ctl_clr,
    output logic [FLAGS_W-1:0] flags
);
    logic [FLAGS_W-1:0] nxt;

    // Merge the ALU update and the control strobes into the next word.
    always_comb begin
        nxt = flags;
        if (alu_upd) begin
            for (int k = 0; k < NUM_AF; k++) nxt[af_pos(k)] = af_next[k];
        end
        for (int j = 0; j < NUM_CTL; j++) begin
            nxt[ctl_pos(j)] = (flags[ctl_pos(j)] | ctl_set[j]) & ~ctl_clr[j];
        end
    end

    // Register the word; reset clears it, a load overrides everything else.
    always_ff @(posedge clk) begin
        if (!rst_n)       flags <= '0;
        else if (load_en) flags <= load_word & USED_MASK;
        else              flags <= nxt & USED_MASK;
    end
endmodule

// File: rtl/sfg_status_unit.sv
// Top of the status flag generator: datapath, policy stage and flags register.
// Assumes the caller holds inputs stable around the clock edge.
module sfg_status_unit
    import sfg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_valid,
    input  logic [2:0]               op_code,
    input  logic [1:0]               op_size,
    input  logic [DATA_W-1:0]        opnd_a,
    input  logic [DATA_W-1:0]        opnd_b,
    input  logic [NUM_AF*POL_W-1:0]  flag_policy,
    input  logic [NUM_CTL-1:0]       ctl_set,
    input  logic [NUM_CTL-1:0]       ctl_clr,
    input  logic                     load_en,
    input  logic [FLAGS_W-1:0]       load_word,
    output logic [DATA_W-1:0]        result,
    output logic [FLAGS_W-1:0]       flags
);
    logic              c_raw, o_raw, s_raw, z_raw, is_logic;
    logic [NUM_AF-1:0] af_next;
    logic              alu_upd;

    assign alu_upd = op_valid && (op_code != OP_RSV);

    sfg_arith u_arith (
        .op_code (op_code),
        .op_size (op_size),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .carry_in(flags[0]),
        .result  (result),
        .c_raw   (c_raw),
        .o_raw   (o_raw),
        .s_raw   (s_raw),
        .z_raw   (z_raw),
        .is_logic(is_logic)
    );

    sfg_flag_eval u_eval (
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .result     (result),
        .c_raw      (c_raw),
        .o_raw      (o_raw),
        .s_raw      (s_raw),
        .z_raw      (z_raw),
        .is_logic   (is_logic),
        .flag_policy(flag_policy),
        .cur_flags  (flags),
        .af_next    (af_next)
    );

    sfg_flag_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_word(load_word),
        .alu_upd  (alu_upd),
        .af_next  (af_next),
        .ctl_set  (ctl_set),
        .ctl_clr  (ctl_clr),
        .flags    (flags)
    );
endmodule

// File: rtl/sfg_status_checker.sv
// Property checker for sfg_status_unit, attached through bind.
module sfg_status_checker
    import sfg_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     op_valid,
    input logic [2:0]               op_code,
    input logic [NUM_AF*POL_W-1:0]  flag_policy,
    input logic [NUM_CTL-1:0]       ctl_set,
    input logic [NUM_CTL-1:0]       ctl_clr,
    input logic                     load_en,
    input logic [FLAGS_W-1:0]       load_word,
    input logic [DATA_W-1:0]        result,
    input logic [FLAGS_W-1:0]       flags
);
    // R1: unused bits never read back as 1.
    assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~USED_MASK) == '0);

    // R11: a load shows exactly the masked load value next cycle.
    assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> flags == ($past(load_word) & USED_MASK));

    // R10: without load or strobes, the control bits hold.
    assert_ctl_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && ctl_set == '0 && ctl_clr == '0) |=> $stable(flags[10:8]));

    // R12: no valid operation leaves the arithmetic bits unchanged.
    assert_af_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && (!op_valid || op_code == OP_RSV))
        |=> ($stable(flags[7:0]) && $stable(flags[11])));

    // R6: computed parity matches the low result byte.
    assert_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !load_en && op_code != OP_RSV && flag_policy[3:2] == 2'd0)
        |=> flags[2] == ~^$past(result[7:0]));

    // R8: logic operations leave carry clear under the compute policy.
    assert_logic_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !load_en && op_code inside {OP_AND, OP_OR, OP_XOR}
         && flag_policy[1:0] == 2'd0) |=> !flags[0]);
endmodule

bind sfg_status_unit sfg_status_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .flag_policy(flag_policy),
    .ctl_set    (ctl_set),
    .ctl_clr    (ctl_clr),
    .load_en    (load_en),
    .load_word  (load_word),
    .result     (result),
    .flags      (flags)
);

// File: tb/sim_sfg_status_unit.sv
module sim_sfg_status_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [1:0]  op_size;
    logic [31:0] opnd_a, opnd_b;
    logic [11:0] flag_policy;
    logic [2:0]  ctl_set, ctl_clr;
    logic        load_en;
    logic [15:0] load_word;
    logic [31:0] result;
    logic [15:0] flags;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sfg_status_unit u0 (.*);

    // {size[2], op[3], a[32], b[32], preload[16], exp_result[32], exp_flags[16]}
    localparam int NV = 12;
    localparam logic [132:0] VEC [NV] = '{
        {2'd0, 3'd0, 32'hABCDEF7F, 32'h00000001, 16'h0000, 32'h00000080, 16'h0890},
        {2'd0, 3'd0, 32'h000000FF, 32'h00000001, 16'h0700, 32'h00000000, 16'h0755},
        {2'd1, 3'd1, 32'h00007FFF, 32'h00000000, 16'h0001, 32'h00008000, 16'h0894},
        {2'd0, 3'd2, 32'h00000000, 32'h00000001, 16'h0000, 32'h000000FF, 16'h0095},
        {2'd0, 3'd3, 32'h00000080, 32'h00000000, 16'h0001, 32'h0000007F, 16'h0810},
        {2'd2, 3'd0, 32'h80000000, 32'h80000000, 16'h0000, 32'h00000000, 16'h0845},
        {2'd2, 3'd4, 32'hF0F000FF, 32'h0FF00103, 16'h0001, 32'h00F00003, 16'h0004},
        {2'd1, 3'd5, 32'h00008000, 32'h00000001, 16'h0010, 32'h00008001, 16'h0090},
        {2'd0, 3'd6, 32'h0001235A, 32'h0000005A, 16'h0801, 32'h00000000, 16'h0044},
        {2'd1, 3'd2, 32'h00001234, 32'h00001234, 16'h0000, 32'h00000000, 16'h0044},
        {2'd3, 3'd0, 32'h0000FFFF, 32'h00000001, 16'h0000, 32'h00010000, 16'h0014},
        {2'd1, 3'd3, 32'h00000000, 32'h0000FFFF, 16'h0001, 32'h00000000, 16'h0055}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        op_valid = 0; op_code = 0; op_size = 0; opnd_a = 0; opnd_b = 0;
        flag_policy = 0; ctl_set = 0; ctl_clr = 0; load_en = 0; load_word = 0;
    endtask

    // Load a word over one edge; returns at the following falling edge.
    task automatic load(input logic [15:0] w);
        load_en = 1; load_word = w;
        @(negedge clk);
        load_en = 0;
    endtask

    task automatic op(input logic [2:0] c, input logic [1:0] s,
                      input logic [31:0] a, input logic [31:0] b);
        op_valid = 1; op_code = c; op_size = s; opnd_a = a; opnd_b = b;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check(flags == 16'h0000, "R1 reset", 32'(flags), 32'h0);
        rst_n = 1;
        @(negedge clk);

        // Vector walk: preload, execute, check result then flags.
        for (int i = 0; i < NV; i++) begin
            load(VEC[i][63:48]);
            op(VEC[i][130:128], VEC[i][132:131], VEC[i][127:96], VEC[i][95:64]);
            #1;
            check(result == VEC[i][47:16], $sformatf("R2 R3 result vec%0d", i),
                  result, VEC[i][47:16]);
            @(negedge clk);
            op_valid = 0;
            check(flags == VEC[i][15:0],
                  $sformatf("R3 R4 R5 R6 R7 R8 flags vec%0d", i),
                  32'(flags), 32'(VEC[i][15:0]));
        end

        // R1: unused bits drop on load.
        load(16'hFFFF);
        check(flags == 16'h0FD5, "R1 unused bits", 32'(flags), 32'h0FD5);

        // R9: carry forced 1, parity kept, zero forced 1, sign forced 0.
        load(16'h0004);
        op(3'd0, 2'd0, 32'h1, 32'h1);
        flag_policy = 12'h18E;
        @(negedge clk);
        idle();
        check(flags == 16'h0045, "R9 policy", 32'(flags), 32'h0045);

        // R10: operation and strobes in the same cycle.
        load(16'h0000);
        op(3'd0, 2'd0, 32'h7F, 32'h1);
        ctl_set = 3'b101;
        @(negedge clk);
        idle();
        check(flags == 16'h0D90, "R10 op with strobe", 32'(flags), 32'h0D90);
        ctl_clr = 3'b001; ctl_set = 3'b010;
        @(negedge clk);
        idle();
        check(flags == 16'h0B90, "R10 strobe only", 32'(flags), 32'h0B90);
        ctl_set = 3'b100; ctl_clr = 3'b100;
        @(negedge clk);
        idle();
        check(flags == 16'h0A90, "R10 clear wins", 32'(flags), 32'h0A90);

        // R11: load beats operation and strobes.
        load_en = 1; load_word = 16'h0001;
        op(3'd0, 2'd0, 32'hFF, 32'h1);
        ctl_set = 3'b111;
        @(negedge clk);
        idle();
        check(flags == 16'h0001, "R11 load priority", 32'(flags), 32'h0001);

        // R12: idle operands and reserved code leave flags alone.
        op(3'd0, 2'd0, 32'hFF, 32'h1);
        op_valid = 0;
        @(negedge clk);
        check(flags == 16'h0001, "R12 no valid", 32'(flags), 32'h0001);
        op(3'd7, 2'd2, 32'h1234, 32'h5678);
        #1;
        check(result == 32'h0, "R2 reserved result", result, 32'h0);
        @(negedge clk);
        idle();
        check(flags == 16'h0001, "R12 reserved code", 32'(flags), 32'h0001);

        // R1: reset clears a loaded word.
        load(16'h0FD5);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check(flags == 16'h0000, "R1 reset clears", 32'(flags), 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule